// File: doc/BRIEF.md
# Control Endpoint Transaction Manager (Control Read)

This block runs the device side of a control endpoint while the host performs control read transfers. Decoded token events come in from the packet layer: SETUP, IN or OUT, with a payload length and a zero-length marker. For each token the block returns a handshake decision one cycle later. It follows the transfer through its setup, data and status stages. It also settles conflicts between the CPU, which loads and arms the IN bank, and the host, which may close the data stage at any moment.

The CPU sees three flags: setup seen, OUT data taken, and IN bank free. It clears a flag by writing 1 to the matching bit of a clear strobe. Writing 1 to the IN-bank bit also arms the bank, so that its data goes out on the next IN token. An interrupt enable register masks the flags onto one interrupt line. Two strobes are also produced: a FIFO reset pulse on every SETUP, and a flush pulse when a status stage discards IN data.

Top module: `ctl_ep_mgr`

## Requirements
- R1: After reset the stage is IDLE (0), all three flags are 0, hs_valid is 0, irq is 0 and both byte counters read 0.
- R2: A SETUP token (tok_kind 0) in any stage is answered with ACK. hs_code 1 appears with hs_valid one cycle later. In that same cycle the stage is SETUP (1), flags reads only bit 0 (setup seen) set, fifo_rst pulses, tx_count is 0 and rx_count equals the SETUP length.
- R3: An IN token (tok_kind 1) in stage SETUP or DATA_IN gets ACK only if the CPU has armed the bank by writing 1 to clear bit 2. The ACK moves the stage to DATA_IN (2), sets flag bit 2 (IN bank free), empties tx_count and disarms the bank. Without arming, the reply is NAK (hs_code 2) and the stage is unchanged. Each cpu_fifo_wr outside the status stage adds one to tx_count.
- R4: The first OUT token (tok_kind 2) in DATA_IN is answered with NAK and moves the stage to STATUS_WAIT_RETRY (3). It pulses in_flush, empties tx_count and disarms the bank.
- R5: In STATUS_WAIT_RETRY and STATUS_DONE, a CPU clear of flag bit 2 has no effect and cpu_fifo_wr does not change tx_count.
- R6: An OUT token in STATUS_WAIT_RETRY is answered with ACK. It sets flag bit 1 (OUT taken) and flag bit 2, and moves the stage to STATUS_DONE (4). There, IN and OUT tokens get NAK and the stage stays until a SETUP arrives.
- R7: An accepted status OUT with tok_zlp high sets rx_count to 0. With tok_zlp low it adds tok_bytes to rx_count.
- R8: A token that does not fit the sequence is answered with NAK and returns the stage to IDLE. This covers IN or OUT in IDLE, OUT in SETUP, and IN in STATUS_WAIT_RETRY.
- R9: When hardware sets a flag in the same cycle that the CPU clears it, the flag ends up set.
- R10: irq is high exactly when some flag bit and the same bit of the enable register (written by ien_wr with ien_wdata) are both 1.
- R11: A clear strobe lowers only the flag bits whose clear_mask bit is 1. Bits written as 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token event present this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 no token |
| tok_zlp | input | 1 | OUT/SETUP packet carries no data |
| tok_bytes | input | CNT_W | Payload length of the packet |
| cpu_fifo_wr | input | 1 | CPU writes one byte into the IN bank |
| clr_wr | input | 1 | CPU flag-clear strobe |
| clr_mask | input | 3 | Bits to clear (bit 2 also arms the IN bank) |
| ien_wr | input | 1 | Interrupt enable register write strobe |
| ien_wdata | input | 3 | New interrupt enable value |
| hs_valid | output | 1 | Handshake decision present |
| hs_code | output | 2 | 1 ACK, 2 NAK |
| flags | output | 3 | bit0 setup seen, bit1 OUT taken, bit2 IN bank free |
| irq | output | 1 | Masked OR of the flags |
| fifo_rst | output | 1 | One-cycle FIFO reset on SETUP |
| in_flush | output | 1 | One-cycle discard of IN data at status start |
| stage | output | 3 | Current transfer stage |
| rx_count | output | CNT_W | Received byte counter |
| tx_count | output | CNT_W | Bytes written into the IN bank |

## Verification
The first status OUT is a key case: a design that ACKs it, or leaves tx_count or the arming in place, would send stale IN data or finish early. The bench clears the IN-bank flag and writes bytes during the status stage, because a design that honours those writes would corrupt state the host already considers closed. It clears all flags in the same cycle as a SETUP, where a clear-wins design would lose the setup flag. It also drives OUT and IN tokens out of order, where a lax design would ACK or stall in a middle stage.

// File: rtl/ctl_ep_pkg.sv
// Shared encodings for the control endpoint manager.
// Assumes: token and handshake codes are fixed by the packet layer interface.
package ctl_ep_pkg;
    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2,
        TOK_NONE  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SETUP      = 3'd1,
        ST_DATA_IN    = 3'd2,
        ST_STAT_RETRY = 3'd3,
        ST_STAT_DONE  = 3'd4
    } stage_e;

    localparam int FLAG_N   = 3;
    localparam int FL_SETUP = 0;
    localparam int FL_OUTRX = 1;
    localparam int FL_INRDY = 2;
endpackage

// File: rtl/ctl_ep_stage.sv
// Stage machine of a control read transfer and handshake decision.
// Decides ACK/NAK from the current stage and the IN bank arming, registers
// the decision, and emits single-cycle events used by the flag and bank logic.
// Assumes: at most one token per cycle; SETUP always overrides.
module ctl_ep_stage
    import ctl_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       bank_armed,
    output stage_e     stage_q,
    output logic       hs_valid_q,
    output logic [1:0] hs_code_q,
    output logic       ev_setup,
    output logic       ev_in_sent,
    output logic       ev_status_first,
    output logic       ev_status_ack,
    output logic       status_lock
);
    stage_e stage_d;
    hs_e    hs_d;
    tok_e   kind;

    assign kind        = tok_e'(tok_kind);
    assign status_lock = (stage_q == ST_STAT_RETRY) || (stage_q == ST_STAT_DONE);

    // Next stage, handshake and events from the current token.
    always_comb begin
        stage_d         = stage_q;
        hs_d            = HS_NONE;
        ev_setup        = 1'b0;
        ev_in_sent      = 1'b0;
        ev_status_first = 1'b0;
        ev_status_ack   = 1'b0;
        if (tok_valid) begin
            case (kind)
                TOK_SETUP: begin
                    stage_d  = ST_SETUP;
                    hs_d     = HS_ACK;
                    ev_setup = 1'b1;
                end
                TOK_IN: begin
                    case (stage_q)
                        ST_SETUP, ST_DATA_IN: begin
                            if (bank_armed) begin
                                hs_d       = HS_ACK;
                                ev_in_sent = 1'b1;
                                stage_d    = ST_DATA_IN;
                            end else begin
                                hs_d = HS_NAK;
                            end
                        end
                        ST_STAT_DONE: hs_d = HS_NAK;
                        default: begin
                            hs_d    = HS_NAK;
                            stage_d = ST_IDLE;
                        end
                    endcase
                end
                TOK_OUT: begin
                    case (stage_q)
                        ST_DATA_IN: begin
                            hs_d            = HS_NAK;
                            ev_status_first = 1'b1;
                            stage_d         = ST_STAT_RETRY;
                        end
                        ST_STAT_RETRY: begin
                            hs_d          = HS_ACK;
                            ev_status_ack = 1'b1;
                            stage_d       = ST_STAT_DONE;
                        end
                        ST_STAT_DONE: hs_d = HS_NAK;
                        default: begin
                            hs_d    = HS_NAK;
                            stage_d = ST_IDLE;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Stage and handshake registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q    <= ST_IDLE;
            hs_valid_q <= 1'b0;
            hs_code_q  <= HS_NONE;
        end else begin
            stage_q    <= stage_d;
            hs_valid_q <= (hs_d != HS_NONE);
            hs_code_q  <= hs_d;
        end
    end

    assert_setup_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_SETUP) |=>
        (hs_valid_q && hs_code_q == HS_ACK && stage_q == ST_SETUP));

    assert_unarmed_in_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_IN && !bank_armed) |=> (hs_code_q == HS_NAK));

    assert_first_status_nak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_OUT && stage_q == ST_DATA_IN) |=>
        (hs_code_q == HS_NAK && stage_q == ST_STAT_RETRY));

    assert_retry_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_OUT && stage_q == ST_STAT_RETRY) |=>
        (hs_code_q == HS_ACK && stage_q == ST_STAT_DONE));
endmodule

// File: rtl/ctl_ep_inbank.sv
// IN bank bookkeeping: arming by the CPU, byte count, flush and reset pulses.
// Assumes: arming and writes are refused once the status stage has begun.
module ctl_ep_inbank
    import ctl_ep_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_fifo_wr,
    input  logic             commit_req,
    input  logic             status_lock,
    input  logic             ev_setup,
    input  logic             ev_in_sent,
    input  logic             ev_status_first,
    output logic             bank_armed,
    output logic [CNT_W-1:0] tx_count,
    output logic             in_flush_q,
    output logic             fifo_rst_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wipe;
    assign wipe = ev_setup || ev_status_first;

    // Arming state: wiped by SETUP or status, consumed by a sent IN.
    always_ff @(posedge clk) begin
        if (!rst_n)                          bank_armed <= 1'b0;
        else if (wipe)                       bank_armed <= 1'b0;
        else if (commit_req && !status_lock) bank_armed <= 1'b1;
        else if (ev_in_sent)                 bank_armed <= 1'b0;
    end

    // Pending IN byte count, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                      tx_count <= '0;
        else if (wipe || ev_in_sent)     tx_count <= '0;
        else if (cpu_fifo_wr && !status_lock && tx_count != CNT_MAX)
                                         tx_count <= tx_count + 1'b1;
    end

    // One-cycle strobes toward the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flush_q <= 1'b0;
            fifo_rst_q <= 1'b0;
        end else begin
            in_flush_q <= ev_status_first;
            fifo_rst_q <= ev_setup;
        end
    end

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_status_first |=> (tx_count == '0 && !bank_armed && in_flush_q));

    assert_locked_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_lock && !ev_setup) |=> ($stable(tx_count) && !bank_armed));
endmodule

// File: rtl/ctl_ep_flags.sv
// CPU-visible flags with write-1-to-clear, interrupt enable and interrupt.
// Assumes: a hardware set beats a same-cycle CPU clear; wipe clears the rest.
module ctl_ep_flags
    import ctl_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic              wipe,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_mask,
    input  logic [FLAG_N-1:0] clr_block,
    input  logic              ien_wr,
    input  logic [FLAG_N-1:0] ien_wdata,
    output logic [FLAG_N-1:0] flags_q,
    output logic              irq
);
    logic [FLAG_N-1:0] ien_q;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        // One flag: set first, then wipe, then an unblocked CPU clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   flags_q[i] <= 1'b0;
            else if (set_vec[i])                          flags_q[i] <= 1'b1;
            else if (wipe)                                flags_q[i] <= 1'b0;
            else if (clr_wr && clr_mask[i] && !clr_block[i]) flags_q[i] <= 1'b0;
        end

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags_q[i]);

        assert_blocked_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_block[i] && !wipe && flags_q[i]) |=> flags_q[i]);

        assert_masked_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && !clr_mask[i] && !wipe && flags_q[i]) |=> flags_q[i]);
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    assign irq = |(flags_q & ien_q);
endmodule

// File: rtl/ctl_ep_mgr.sv
// Control endpoint transaction manager for control read transfers (top).
// Ties the stage machine, IN bank logic and flag bank together and keeps
// the received byte counter. Assumes decoded tokens, one per cycle.
module ctl_ep_mgr
    import ctl_ep_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             tok_zlp,
    input  logic [CNT_W-1:0] tok_bytes,
    input  logic             cpu_fifo_wr,
    input  logic             clr_wr,
    input  logic [2:0]       clr_mask,
    input  logic             ien_wr,
    input  logic [2:0]       ien_wdata,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic [2:0]       flags,
    output logic             irq,
    output logic             fifo_rst,
    output logic             in_flush,
    output logic [2:0]       stage,
    output logic [CNT_W-1:0] rx_count
    ,output logic [CNT_W-1:0] tx_count
);
    stage_e            stage_q;
    logic              bank_armed;
    logic              ev_setup, ev_in_sent, ev_status_first, ev_status_ack;
    logic              status_lock;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_block;

    ctl_ep_stage u_stage (
        .clk             (clk),
        .rst_n           (rst_n),
        .tok_valid       (tok_valid),
        .tok_kind        (tok_kind),
        .bank_armed      (bank_armed),
        .stage_q         (stage_q),
        .hs_valid_q      (hs_valid),
        .hs_code_q       (hs_code),
        .ev_setup        (ev_setup),
        .ev_in_sent      (ev_in_sent),
        .ev_status_first (ev_status_first),
        .ev_status_ack   (ev_status_ack),
        .status_lock     (status_lock)
    );

    ctl_ep_inbank #(.CNT_W(CNT_W)) u_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpu_fifo_wr     (cpu_fifo_wr),
        .commit_req      (clr_wr && clr_mask[FL_INRDY]),
        .status_lock     (status_lock),
        .ev_setup        (ev_setup),
        .ev_in_sent      (ev_in_sent),
        .ev_status_first (ev_status_first),
        .bank_armed      (bank_armed),
        .tx_count        (tx_count),
        .in_flush_q      (in_flush),
        .fifo_rst_q      (fifo_rst)
    );

    // Hardware set sources and per-flag clear blocking.
    always_comb begin
        set_vec            = '0;
        set_vec[FL_SETUP]  = ev_setup;
        set_vec[FL_OUTRX]  = ev_status_ack;
        set_vec[FL_INRDY]  = ev_in_sent || ev_status_ack;
        clr_block          = '0;
        clr_block[FL_INRDY] = status_lock;
    end

    ctl_ep_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .wipe      (ev_setup),
        .clr_wr    (clr_wr),
        .clr_mask  (clr_mask),
        .clr_block (clr_block),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .flags_q   (flags),
        .irq       (irq)
    );

    // Received byte counter: loaded by SETUP, zeroed by a zero-length OUT.
    always_ff @(posedge clk) begin
        if (!rst_n)             rx_count <= '0;
        else if (ev_setup)      rx_count <= tok_bytes;
        else if (ev_status_ack) rx_count <= tok_zlp ? '0 : rx_count + tok_bytes;
    end

    assign stage = stage_q;

    assert_zlp_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_status_ack && tok_zlp) |=> (rx_count == '0));

    assert_setup_wipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> (flags == 3'b001 && fifo_rst && tx_count == '0));
endmodule

// File: tb/sim_ctl_ep_mgr.sv
// Directed bench for ctl_ep_mgr: one task per scenario, each self-checking.
module sim_ctl_ep_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tok_valid = 1'b0;
    logic [1:0]       tok_kind = 2'd3;
    logic             tok_zlp = 1'b0;
    logic [CNT_W-1:0] tok_bytes = '0;
    logic             cpu_fifo_wr = 1'b0;
    logic             clr_wr = 1'b0;
    logic [2:0]       clr_mask = '0;
    logic             ien_wr = 1'b0;
    logic [2:0]       ien_wdata = '0;
    logic             hs_valid, irq, fifo_rst, in_flush;
    logic [1:0]       hs_code;
    logic [2:0]       flags, stage;
    logic [CNT_W-1:0] rx_count, tx_count;

    int tests = 0;
    int fails = 0;

    ctl_ep_mgr #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_zlp(tok_zlp), .tok_bytes(tok_bytes), .cpu_fifo_wr(cpu_fifo_wr),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .hs_valid(hs_valid), .hs_code(hs_code), .flags(flags), .irq(irq),
        .fifo_rst(fifo_rst), .in_flush(in_flush), .stage(stage),
        .rx_count(rx_count), .tx_count(tx_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change 1 time unit after the edge.
    task automatic step();
        @(posedge clk);
        #1;
        tok_valid = 1'b0; tok_kind = 2'd3; cpu_fifo_wr = 1'b0;
        clr_wr = 1'b0; clr_mask = '0; ien_wr = 1'b0;
    endtask

    task automatic tok(input logic [1:0] k, input int n, input logic z);
        tok_valid = 1'b1; tok_kind = k; tok_bytes = CNT_W'(n); tok_zlp = z;
        step();
    endtask

    task automatic cpu_clr(input logic [2:0] m);
        clr_wr = 1'b1; clr_mask = m;
        step();
    endtask

    task automatic cpu_wr();
        cpu_fifo_wr = 1'b1;
        step();
    endtask

    task automatic set_ien(input logic [2:0] v);
        ien_wr = 1'b1; ien_wdata = v;
        step();
    endtask

    task automatic t_reset();
        chk("R1 stage", stage, 0);
        chk("R1 flags", flags, 0);
        chk("R1 hs_valid", hs_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
    endtask

    task automatic t_control_read();
        tok(2'd0, 8, 1'b0);
        chk("R2 hs_valid", hs_valid, 1);
        chk("R2 ack", hs_code, 1);
        chk("R2 stage", stage, 1);
        chk("R2 flags", flags, 3'b001);
        chk("R2 fifo_rst", fifo_rst, 1);
        chk("R2 rx_count", rx_count, 8);
        step();
        chk("R2 hs drops", hs_valid, 0);
        tok(2'd1, 0, 1'b0);
        chk("R3 unarmed nak", hs_code, 2);
        chk("R3 stage held", stage, 1);
        repeat (3) cpu_wr();
        chk("R3 tx_count", tx_count, 3);
        cpu_clr(3'b100);
        tok(2'd1, 0, 1'b0);
        chk("R3 armed ack", hs_code, 1);
        chk("R3 stage data", stage, 2);
        chk("R3 in flag", flags, 3'b101);
        chk("R3 tx emptied", tx_count, 0);
        repeat (2) cpu_wr();
        tok(2'd2, 0, 1'b1);
        chk("R4 first status nak", hs_code, 2);
        chk("R4 stage", stage, 3);
        chk("R4 flush", in_flush, 1);
        chk("R4 tx_count", tx_count, 0);
        cpu_clr(3'b100);
        chk("R5 clear ignored", flags, 3'b101);
        cpu_wr();
        chk("R5 write ignored", tx_count, 0);
        tok(2'd2, 0, 1'b1);
        chk("R6 retry ack", hs_code, 1);
        chk("R6 stage done", stage, 4);
        chk("R6 flags", flags, 3'b111);
        chk("R7 zlp rx zero", rx_count, 0);
        tok(2'd1, 0, 1'b0);
        chk("R6 in nak", hs_code, 2);
        chk("R6 stage kept", stage, 4);
        tok(2'd2, 0, 1'b1);
        chk("R6 out nak", hs_code, 2);
    endtask

    task automatic t_set_wins();
        clr_wr = 1'b1; clr_mask = 3'b111;
        tok(2'd0, 8, 1'b0);
        chk("R9 set wins", flags, 3'b001);
        cpu_clr(3'b010);
        chk("R11 masked bit kept", flags, 3'b001);
        cpu_clr(3'b001);
        chk("R11 bit cleared", flags, 3'b000);
    endtask

    task automatic t_irq();
        set_ien(3'b001);
        chk("R10 irq low", irq, 0);
        tok(2'd0, 8, 1'b0);
        chk("R10 irq high", irq, 1);
        set_ien(3'b110);
        chk("R10 irq masked", irq, 0);
        set_ien(3'b000);
    endtask

    task automatic t_out_of_seq();
        tok(2'd2, 0, 1'b1);
        chk("R8 out in setup nak", hs_code, 2);
        chk("R8 to idle", stage, 0);
        tok(2'd1, 0, 1'b0);
        chk("R8 in in idle nak", hs_code, 2);
        chk("R8 idle kept", stage, 0);
        tok(2'd0, 8, 1'b0);
        cpu_clr(3'b100);
        tok(2'd1, 0, 1'b0);
        tok(2'd2, 0, 1'b1);
        tok(2'd1, 0, 1'b0);
        chk("R8 in during retry nak", hs_code, 2);
        chk("R8 retry to idle", stage, 0);
    endtask

    task automatic t_rx_count();
        tok(2'd0, 8, 1'b0);
        cpu_clr(3'b100);
        tok(2'd1, 0, 1'b0);
        tok(2'd2, 0, 1'b1);
        tok(2'd2, 4, 1'b0);
        chk("R7 rx adds", rx_count, 12);
        tok(2'd0, 8, 1'b0);
        chk("R2 rx reload", rx_count, 8);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
        t_reset();
        t_control_read();
        t_set_wins();
        t_irq();
        t_out_of_seq();
        t_rx_count();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule